// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is an I2C target that gives a bus master byte access to a 64-location register space. Locations 0x00 to 0x06 hold the time of day and date, 0x07 is a control byte and 0x08 to 0x3F are spare RAM. SCL and SDA are oversampled with the fast system clock. The block finds START, repeated START and STOP on the bus. It answers to the 7-bit address 0x68, shifts bytes in and out, and pulls SDA low through an output-enable pin only. It does not stretch the clock, and it has neither 10-bit addressing nor general call.

All access goes through an internal 6-bit pointer. A write transaction loads the pointer from its first data byte, and later bytes go to consecutive locations. A read continues from the pointer. A random read is therefore a pointer write, then a repeated START, then a read. The storage sits outside the block behind a plain port: an address that always shows the pointer, a one-cycle write strobe with data, and a combinational read-data input.

The control byte stores its output level in bit 7, the square-wave enable in bit 4 and the rate select in bits 1:0. Bits 6, 5, 3 and 2 are reserved. The block stores and returns this byte like any other location.

Top module: `i2c_regptr_target`

## Requirements
- R1: A START followed by address 0x68 with R/W=0 (byte 0xD0) is acknowledged. Every data byte written after it is also acknowledged by pulling SDA low in the ninth clock.
- R2: After a START with any other address, the block sends no ACK and performs no write, and it ignores all further bytes until the next START. The pointer keeps its value.
- R3: In a write transaction, the first data byte loads the pointer with its low 6 bits. Each later byte is written to the pointed location, and the pointer then increments.
- R4: The pointer wraps from 0x3F to 0x00 on both writes and reads.
- R5: A pointer write, then a repeated START, then address 0x68 with R/W=1 (byte 0xD1) returns bytes MSB first from consecutive locations, starting at the loaded pointer.
- R6: A master NACK after a read byte ends the transfer and SDA is released. The pointer has already advanced past the last byte sent, so a following read without a pointer write starts at the next location.
- R7: SDA is only ever pulled low and never driven high. The block starts pulling only while SCL is low.
- R8: A STOP, or a START in the middle of a byte, abandons the partial byte without writing anything, and the pointer keeps its value.
- R9: After reset, SDA is released, no write is strobed and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| sda_drive_low | output | 1 | 1 = pull SDA low; 0 = release |
| mem_addr | output | 6 | Storage address, equal to the pointer |
| mem_we | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte stored at mem_addr |

## Verification
Two things can land on the same SCL falling edge: the write strobe for a data byte and the pointer increment. At the 0x3F to 0x00 wrap the increment and the write address must not mix up, so the bench writes across the boundary and reads it back. The same edge also ends a read byte and advances the pointer, while the master's NACK decides whether another byte follows. To provoke this, a read is ended with NACK and then a current-address read is issued with no pointer write. Randomised write-then-read-back transfers at random pointers and lengths are compared against a reference byte array kept by the bench.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_PTR, S_PACK, S_WR, S_WACK, S_RD, S_MACK
  } rp_state_t;
endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], din[g]};
    end
    assign dout[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/i2c_rp_cond.sv
module i2c_rp_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rp_core.sv
module i2c_rp_core
  import i2c_rp_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         AW       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              sda_drive_low
);
  localparam int          CW      = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] FULL  = CW'(BYTE_W);
  localparam logic [CW-1:0] LAST  = CW'(BYTE_W - 1);
  localparam logic [AW-1:0] ONE   = AW'(1);

  rp_state_t         st, st_n;
  logic [CW-1:0]     bcnt, bcnt_n;
  logic [BYTE_W-1:0] sh, sh_n;
  logic [AW-1:0]     ptr, ptr_n;
  logic              rd, rd_n;
  logic              mack, mack_n;
  logic              we;

  always_comb begin
    st_n = st; bcnt_n = bcnt; sh_n = sh; ptr_n = ptr;
    rd_n = rd; mack_n = mack; we = 1'b0;
    if (stop_evt) begin
      st_n = S_IDLE; bcnt_n = '0;
    end else if (start_evt) begin
      st_n = S_ADDR; bcnt_n = '0;
    end else begin
      unique case (st)
        S_ADDR, S_PTR, S_WR: begin
          if (scl_rise && bcnt != FULL) begin
            sh_n   = {sh[BYTE_W-2:0], sda_s};
            bcnt_n = bcnt + 1'b1;
          end else if (scl_fall && bcnt == FULL) begin
            bcnt_n = '0;
            if (st == S_ADDR) begin
              if (sh[BYTE_W-1:1] == DEV_ADDR) begin
                st_n = S_AACK; rd_n = sh[0];
              end else begin
                st_n = S_IDLE;
              end
            end else if (st == S_PTR) begin
              ptr_n = sh[AW-1:0]; st_n = S_PACK;
            end else begin
              we = 1'b1; ptr_n = ptr + ONE; st_n = S_WACK;
            end
          end
        end
        S_AACK: if (scl_fall) begin
          if (rd) begin st_n = S_RD; sh_n = mem_rdata; end
          else          st_n = S_PTR;
        end
        S_PACK, S_WACK: if (scl_fall) st_n = S_WR;
        S_RD: if (scl_fall) begin
          sh_n   = {sh[BYTE_W-2:0], 1'b0};
          bcnt_n = bcnt + 1'b1;
          if (bcnt == LAST) begin
            st_n = S_MACK; bcnt_n = '0; ptr_n = ptr + ONE;
          end
        end
        S_MACK: begin
          if (scl_rise) mack_n = ~sda_s;
          if (scl_fall) begin
            if (mack) begin st_n = S_RD; sh_n = mem_rdata; end
            else            st_n = S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bcnt <= '0; sh <= '0; ptr <= '0; rd <= 1'b0; mack <= 1'b0;
    end else begin
      st <= st_n; bcnt <= bcnt_n; sh <= sh_n; ptr <= ptr_n; rd <= rd_n; mack <= mack_n;
    end
  end

  assign mem_addr      = ptr;
  assign mem_we        = we;
  assign mem_wdata     = sh;
  assign sda_drive_low = (st == S_AACK) || (st == S_PACK) || (st == S_WACK) ||
                         ((st == S_RD) && !sh[BYTE_W-1]);
endmodule

// File: rtl/i2c_regptr_target.sv
module i2c_regptr_target #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         AW       = 6,
  parameter int         SYNC_STG = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scl_i,
  input  logic         sda_i,
  output logic         sda_drive_low,
  output logic [AW-1:0] mem_addr,
  output logic         mem_we,
  output logic [7:0]   mem_wdata,
  input  logic [7:0]   mem_rdata
);
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  i2c_rp_sync #(.N(2), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .din({scl_i, sda_i}), .dout({scl_s, sda_s})
  );

  i2c_rp_cond u_cond (
    .clk(clk), .rst_n(rst_n_s), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_rp_core #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_core (
    .clk(clk), .rst_n(rst_n_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .sda_drive_low(sda_drive_low)
  );
endmodule

// File: rtl/i2c_regptr_chk.sv
module i2c_regptr_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          start_evt,
  input logic          stop_evt,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          sda_drive_low
);
  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_addr == $past(mem_addr) + AW'(1)));
  // R1
  wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sda_drive_low);
  // R7
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> !scl_s);
  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sda_drive_low && $stable(mem_addr)));
  // R8
  start_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> !mem_we);
endmodule

bind i2c_regptr_target i2c_regptr_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .scl_s(scl_s), .start_evt(start_evt),
  .stop_evt(stop_evt), .mem_we(mem_we), .mem_addr(mem_addr),
  .sda_drive_low(sda_drive_low)
);

// File: tb/tb_i2c_regptr_target.sv
module tb_i2c_regptr_target;
  localparam int HALF = 10;
  logic clk, rst_n, scl_m, sda_m;
  logic sda_drive_low, mem_we;
  logic [5:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] store [64];
  logic [7:0] ref_mem [64];
  logic       sda_bus;
  int total, bad, r7_viol, hi_cnt;
  logic prev_drv, done;

  assign sda_bus   = sda_m & ~sda_drive_low;
  assign mem_rdata = store[mem_addr];

  i2c_regptr_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_drive_low(sda_drive_low), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) if (mem_we) store[mem_addr] <= mem_wdata;

  always @(negedge clk) begin
    hi_cnt <= scl_m ? hi_cnt + 1 : 0;
    if (sda_drive_low && !prev_drv && hi_cnt >= 3) r7_viol <= r7_viol + 1;
    prev_drv <= sda_drive_low;
  end

  function automatic logic [5:0] nxt(input logic [5:0] p);
    return p + 6'd1;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hp(); repeat (HALF) @(negedge clk); endtask
  task automatic i2c_start(); sda_m = 1; scl_m = 1; hp(); sda_m = 0; hp(); scl_m = 0; endtask
  task automatic i2c_rstart(); sda_m = 1; hp(); scl_m = 1; hp(); sda_m = 0; hp(); scl_m = 0; endtask
  task automatic i2c_stop(); sda_m = 0; hp(); scl_m = 1; hp(); sda_m = 1; hp(); endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hp(); scl_m = 1; hp(); scl_m = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    sda_m = 1; hp(); scl_m = 1; hp(); acked = ~sda_bus; scl_m = 0;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    sda_m = 1; b = '0;
    for (int i = 0; i < 8; i++) begin
      hp(); scl_m = 1; hp(); b = {b[6:0], sda_bus}; scl_m = 0;
    end
    sda_m = ~ack; hp(); scl_m = 1; hp(); scl_m = 0; hp(); sda_m = 1;
  endtask

  task automatic write_seq(input logic [5:0] p, input int n, input logic [7:0] d [4], input string req);
    logic a;
    logic [5:0] q;
    i2c_start();
    send_byte(8'hD0, a); chk(a, "R1", a, 1);
    send_byte({2'b00, p}, a); chk(a, "R1", a, 1);
    q = p;
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a); chk(a, req, a, 1);
      ref_mem[q] = d[i]; q = nxt(q);
    end
    i2c_stop();
  endtask

  task automatic read_seq(input logic [5:0] p, input int n, input string req);
    logic a;
    logic [7:0] b;
    logic [5:0] q;
    i2c_start();
    send_byte(8'hD0, a); send_byte({2'b00, p}, a);
    i2c_rstart();
    send_byte(8'hD1, a); chk(a, "R5", a, 1);
    q = p;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk(b == ref_mem[q], req, b, ref_mem[q]); q = nxt(q);
    end
    i2c_stop();
  endtask

  task automatic cur_read(input logic [5:0] p, input string req);
    logic a;
    logic [7:0] b;
    i2c_start();
    send_byte(8'hD1, a);
    recv_byte(1'b0, b);
    chk(b == ref_mem[p], req, b, ref_mem[p]);
    i2c_stop();
  endtask

  initial begin
    logic [7:0] d [4];
    logic a;
    int unsigned seed;
    total = 0; bad = 0; r7_viol = 0; hi_cnt = 0; prev_drv = 0; done = 0;
    seed = $urandom(32'd1234);
    for (int i = 0; i < 64; i++) begin store[i] = 8'(i * 7 + 3); ref_mem[i] = 8'(i * 7 + 3); end
    scl_m = 1; sda_m = 1; rst_n = 0;
    repeat (5) @(negedge clk);
    // R9 reset state
    chk(!sda_drive_low, "R9", sda_drive_low, 0);
    chk(!mem_we, "R9", mem_we, 0);
    chk(mem_addr == 0, "R9", mem_addr, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    d = '{8'h12, 8'h81, 8'h5A, 8'h00};
    write_seq(6'h05, 3, d, "R3");
    read_seq(6'h05, 3, "R5");
    // R6: NACK after 0x07, next current read from 0x08
    cur_read(6'h08, "R6");
    chk(!sda_drive_low, "R6", sda_drive_low, 0);

    // R4 wrap on write and read
    d = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    write_seq(6'h3E, 4, d, "R4");
    read_seq(6'h3E, 4, "R4");

    // R2 foreign address: pointer now 0x02
    i2c_start();
    send_byte(8'hA0, a); chk(!a, "R2", a, 0);
    send_byte(8'h00, a); chk(!a, "R2", a, 0);
    send_byte(8'hEE, a); chk(!a, "R2", a, 0);
    i2c_stop();
    cur_read(6'h02, "R2");
    read_seq(6'h00, 1, "R2");

    // R8 abort by STOP mid-byte
    write_seq(6'h20, 0, d, "R8");
    i2c_start(); send_byte(8'hD0, a); send_bits(8'hFF, 3); i2c_stop();
    cur_read(6'h20, "R8");
    // R8 abort by START mid-byte; pointer now 0x21
    i2c_start(); send_byte(8'hD0, a); send_bits(8'h3C, 4);
    i2c_rstart(); send_byte(8'hD1, a);
    begin
      logic [7:0] b;
      recv_byte(1'b0, b);
      chk(b == ref_mem[6'h21], "R8", b, ref_mem[6'h21]);
    end
    i2c_stop();

    // random write/read-back
    for (int it = 0; it < 20; it++) begin
      logic [5:0] p;
      int n;
      p = 6'($urandom % 64);
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < 4; i++) d[i] = 8'($urandom);
      write_seq(p, n, d, "R3");
      read_seq(p, n, "R5");
    end

    chk(r7_viol == 0, "R7", r7_viol, 0);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule